// File: doc/BRIEF.md
# Interrupt Aggregator with Keyed Soft Reset

This block collects six single-cycle event pulses from an SPI master core into sticky pending bits. It qualifies them with a per-source mask and a single master gate, and it drives one level-sensitive interrupt line. Software reads the pending bits and acknowledges them by writing ones back. A separate register, when written with a fixed key word, sends a one-clock reset pulse to the attached core and empties the pending bits.

Access is a plain single-cycle 32-bit register port with no handshake: the block is always ready. A write is taken at the rising clock edge on which `reg_wr` is high. Read data is combinational from the current address and needs no strobe, so there is no back-pressure in either direction. Addresses are byte offsets, and only the four word offsets listed below decode. The offsets and the bit positions of the sources are fixed because driver software depends on them.

Top module: `irq_rst_ctl`

## Requirements
- R1: After `rst_n` is released, every register reads zero, and `irq_o` and `core_rst_o` are low.
- R2: A high `evt_i[k]` at a clock edge sets pending bit k, which is visible at offset 0x20 after that edge. The bit then stays set until it is cleared. Source order: k=0 mode fault, 1 slave-select fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun.
- R3: A write to offset 0x20 clears each pending bit whose data bit is 1. Bits written with 0 are left unchanged.
- R4: When an event and a clear for the same bit arrive in the same cycle, the bit ends up set.
- R5: A write to offset 0x28 stores data bits 5:0 as the source mask. A read of offset 0x28 returns the mask, with bits 31:6 reading zero.
- R6: `irq_o` is high exactly when the master gate is set and at least one bit is both pending and unmasked. It follows register state with no added delay.
- R7: Offset 0x1C holds the master gate in bit 31, and only that bit is stored. While the gate is clear, `irq_o` stays low.
- R8: A write of 0x0000000A to offset 0x40 drives `core_rst_o` high for exactly the one cycle that follows the write edge.
- R9: A write of any other value to offset 0x40 produces no reset pulse and leaves the pending bits unchanged.
- R10: A key write clears all pending bits at its edge, including any event that arrives in the same cycle. The mask and the master gate keep their values.
- R11: Reads of offset 0x40 and of any unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_i | input | 6 | Event pulses, one per source |
| irq_o | output | 1 | Interrupt request, active high |
| core_rst_o | output | 1 | One-clock reset pulse to the attached core |

## Verification
If a pending bit is wrong, it shows in the same cycle on `irq_o` when that source is unmasked and the gate is set, and it shows at once on a read of offset 0x20. A mask or gate that holds the wrong value appears on `irq_o` by the next cycle that has a pending source, and it can be read back directly. A faulty key comparison or pulse register shows on `core_rst_o` in the cycle after the write. The bench compares these outputs every cycle against a reference model during random register traffic, with directed cases for the set-versus-clear race and for a key write that coincides with an event.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int NUM_SRC = 6;

  localparam logic [ADDR_W-1:0] OFS_GATE = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_KRST = 8'h40;

  localparam logic [DATA_W-1:0] RST_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GATE,
    SEL_PEND,
    SEL_MASK,
    SEL_KRST
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_GATE: return SEL_GATE;
      OFS_PEND: return SEL_PEND;
      OFS_MASK: return SEL_MASK;
      OFS_KRST: return SEL_KRST;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               wipe_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic bit_q;

    // Priority: soft-reset wipe, then event set, then write-one clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (wipe_i)     bit_q <= 1'b0;
      else if (evt_i[g])   bit_q <= 1'b1;
      else if (clr_i[g])   bit_q <= 1'b0;
    end
    assign pend_o[g] = bit_q;

    a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[g] && !wipe_i) |=> pend_o[g]);
    a_r2_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[g] && !clr_i[g] && !wipe_i) |=> pend_o[g]);
    a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !evt_i[g]) |=> !pend_o[g]);
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[g] && clr_i[g] && !wipe_i) |=> pend_o[g]);
  end

  a_r10_wipe_empties: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_i |=> (pend_o == '0));
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               wr_gate_i,
  input  logic               gate_wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               gate_o,
  output logic               irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      gate_o <= 1'b0;
    end else begin
      if (wr_mask_i) mask_o <= mask_wdata_i;
      if (wr_gate_i) gate_o <= gate_wdata_i;
    end
  end

  logic [NUM_SRC-1:0] live;
  assign live  = pend_i & mask_o;
  assign irq_o = gate_o & (|live);

  a_r5_mask_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> (mask_o == $past(mask_wdata_i)));
  a_r7_gate_stored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gate_i |=> (gate_o == $past(gate_wdata_i)));
  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_o |-> !irq_o);
  a_r6_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_i & mask_o)));
endmodule

// File: rtl/irq_soft_reset.sv
module irq_soft_reset #(
  parameter int                 DATA_W = 32,
  parameter logic [DATA_W-1:0]  KEY    = 32'h0000_000A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              pulse_o
);
  assign hit_o = wr_i && (wdata_i == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_o <= 1'b0;
    else        pulse_o <= hit_o;
  end

  a_r8_key_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == KEY) |=> pulse_o);
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> !pulse_o);
  a_r9_wrong_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i != KEY) |=> !pulse_o);
endmodule

// File: rtl/irq_rst_ctl.sv
module irq_rst_ctl
  import irq_rst_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NS = NUM_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [NS-1:0] evt_i,
  output logic          irq_o,
  output logic          core_rst_o
);
  localparam int GATE_BIT = DW - 1;

  reg_sel_e sel;
  assign sel = decode_addr(reg_addr);

  logic wr_pend, wr_mask, wr_gate, wr_krst;
  assign wr_pend = reg_wr && (sel == SEL_PEND);
  assign wr_mask = reg_wr && (sel == SEL_MASK);
  assign wr_gate = reg_wr && (sel == SEL_GATE);
  assign wr_krst = reg_wr && (sel == SEL_KRST);

  logic [NS-1:0] clr_mask;
  assign clr_mask = wr_pend ? reg_wdata[NS-1:0] : '0;

  logic          key_hit;
  logic [NS-1:0] pend;
  logic [NS-1:0] mask;
  logic          gate;

  irq_soft_reset #(.DATA_W(DW), .KEY(RST_KEY)) u_krst (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_krst),
    .wdata_i (reg_wdata),
    .hit_o   (key_hit),
    .pulse_o (core_rst_o)
  );

  irq_status_bank #(.NUM_SRC(NS)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (clr_mask),
    .wipe_i (key_hit),
    .pend_o (pend)
  );

  irq_mask_gate #(.NUM_SRC(NS)) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_mask_i    (wr_mask),
    .mask_wdata_i (reg_wdata[NS-1:0]),
    .wr_gate_i    (wr_gate),
    .gate_wdata_i (reg_wdata[GATE_BIT]),
    .pend_i       (pend),
    .mask_o       (mask),
    .gate_o       (gate),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_GATE: reg_rdata[GATE_BIT] = gate;
      SEL_PEND: reg_rdata[NS-1:0]   = pend;
      SEL_MASK: reg_rdata[NS-1:0]   = mask;
      default:  reg_rdata           = '0;
    endcase
  end

  a_r11_quiet_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE || sel == SEL_KRST) |-> (reg_rdata == '0));
  a_r8_pulse_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_krst |=> !core_rst_o);
endmodule

// File: tb/irq_rst_ctl_bench.sv
`timescale 1ns/1ps
module irq_rst_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_i;
  logic        irq_o;
  logic        core_rst_o;

  always #2 clk = ~clk;

  irq_rst_ctl u_irq_rst_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
    .irq_o(irq_o), .core_rst_o(core_rst_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [5:0] m_pend = '0;
  logic [5:0] m_mask = '0;
  logic       m_gate = 1'b0;
  logic       m_rst  = 1'b0;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_gate, 31'b0};
      8'h20:   return {26'b0, m_pend};
      8'h28:   return {26'b0, m_mask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic model_irq();
    return m_gate && (|(m_pend & m_mask));
  endfunction

  function automatic string read_tag(input logic [7:0] a);
    case (a)
      8'h1C:   return "R7 gate readback";
      8'h20:   return "R2 R3 R4 R10 pending readback";
      8'h28:   return "R5 mask readback";
      default: return "R11 quiet readback";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Drives one cycle at a falling edge; optionally checks the read data,
  // advances the model at the rising edge, then checks the outputs.
  task automatic step(input logic [5:0] e, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input bit rd);
    logic       key;
    logic [5:0] clr;
    evt_i = e; reg_wr = w; reg_addr = a; reg_wdata = d;
    #1;
    if (rd) chk(reg_rdata == model_read(a), read_tag(a), reg_rdata, model_read(a));
    @(posedge clk);
    key = w && (a == 8'h40) && (d == 32'h0000_000A);
    clr = (w && a == 8'h20) ? d[5:0] : 6'h0;
    if (key) m_pend = '0;
    else     m_pend = (m_pend & ~clr) | e;
    if (w && a == 8'h28) m_mask = d[5:0];
    if (w && a == 8'h1C) m_gate = d[31];
    m_rst = key;
    @(negedge clk);
    chk(irq_o == model_irq(), "R6 R7 interrupt line", {31'b0, irq_o}, {31'b0, model_irq()});
    chk(core_rst_o == m_rst, "R8 R9 reset pulse", {31'b0, core_rst_o}, {31'b0, m_rst});
  endtask

  task automatic rd(input logic [7:0] a);
    step(6'h0, 1'b0, a, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; evt_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(irq_o == 1'b0, "R1 irq after reset", {31'b0, irq_o}, 32'h0);
    chk(core_rst_o == 1'b0, "R1 pulse after reset", {31'b0, core_rst_o}, 32'h0);
    rd(8'h1C); rd(8'h20); rd(8'h28); rd(8'h40); rd(8'h44);
    // R5: upper mask bits dropped
    step(6'h0, 1'b1, 8'h28, 32'hFFFF_FFFF, 1'b0);
    rd(8'h28);
    // R2 with gate closed (R7), then open the gate (R6)
    step(6'h04, 1'b0, 8'h00, 32'h0, 1'b0);
    rd(8'h20);
    step(6'h0, 1'b1, 8'h1C, 32'h7FFF_FFFF, 1'b0);
    rd(8'h1C);
    step(6'h0, 1'b1, 8'h1C, 32'h8000_0000, 1'b0);
    rd(8'h1C);
    // R4: set and clear together
    step(6'h04, 1'b1, 8'h20, 32'h0000_0004, 1'b0);
    rd(8'h20);
    // R3: write-one clear, zeros untouched
    step(6'h11, 1'b0, 8'h00, 32'h0, 1'b0);
    step(6'h0, 1'b1, 8'h20, 32'h0000_0014, 1'b0);
    rd(8'h20);
    // R9: wrong values to the reset register
    step(6'h0, 1'b1, 8'h40, 32'h0000_000B, 1'b0);
    step(6'h0, 1'b1, 8'h40, 32'h0000_010A, 1'b0);
    rd(8'h20);
    // R8 R10: key write with a coincident event
    step(6'h02, 1'b1, 8'h40, 32'h0000_000A, 1'b0);
    rd(8'h20); rd(8'h28); rd(8'h1C);
    // R6: masked source keeps the line low
    step(6'h08, 1'b1, 8'h28, 32'h0, 1'b0);
    rd(8'h20);
    // Back-to-back key writes
    step(6'h0, 1'b1, 8'h40, 32'h0000_000A, 1'b0);
    step(6'h0, 1'b1, 8'h40, 32'h0000_000A, 1'b0);
    step(6'h0, 1'b0, 8'h00, 32'h0, 1'b0);

    for (int i = 0; i < 5000; i++) begin
      logic [5:0]  e;
      logic [31:0] d;
      int unsigned op;
      e  = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
      d  = $urandom;
      op = $urandom % 10;
      case (op)
        0, 1:    step(e, 1'b1, 8'h20, d, 1'b0);
        2:       step(e, 1'b1, 8'h28, d, 1'b0);
        3:       step(e, 1'b1, 8'h1C, d, 1'b0);
        4:       step(e, 1'b1, 8'h40, ($urandom % 3 == 0) ? 32'h0000_000A : d, 1'b0);
        5:       step(e, 1'b0, 8'h20, d, 1'b1);
        6:       step(e, 1'b0, 8'h28, d, 1'b1);
        7:       step(e, 1'b0, 8'h1C, d, 1'b1);
        8:       step(e, 1'b0, 8'({$urandom % 64, 2'b00}), d, 1'b1);
        default: step(e, 1'b0, 8'h00, d, 1'b0);
      endcase
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule